// File: doc/BRIEF.md
# Configurable Four-Input Logic Cell

A small runtime-programmable logic element. Four cell inputs are each picked from a bank of candidate sources: the external source bus plus the cell's own output, so it can feed back into itself. Four gates each form an OR over any mix of true and complemented inputs, and each gate output can then be inverted. Setting those enables and inverts gives AND, NAND and NOR behaviour by De Morgan's laws, or a constant 0 or 1 when a gate has no enables. The four gate results go into one of eight function modes. Three of them are combinational. Five are stateful: a set/reset latch, two D flip-flop styles, a JK flip-flop and a transparent latch.

The result passes an output polarity stage and an enable stage, and is then registered on the system clock. A flip-flop mode clocks when gate 0 has a rising edge, found by comparing it with its value on the previous system clock. Rising and falling output edges can each set their own sticky flag. A host configures the cell through a byte-wide write port and clears the flags by writing ones.

Top module: `cfg_logic_cell`

## Requirements
- R1: Cell input k (k=0..3) is the bank bit at the index in register 1+k. Indexes 0..NSRC-1 pick `src` bits, and index NSRC picks the cell's own `cell_out`.
- R2: Gate k uses register 5+k and bit k of register 9. It is 1 when any input j has bit j set and the input high, or has bit 4+j set and the input low. Bit k of register 9 then inverts the gate. A gate with no enable bits gives 0, or 1 when inverted.
- R3: Combinational modes, taken from register 0 bits [6:4]: 0 gives (g0&g1)|(g2&g3), 1 gives (g0|g1)^(g2|g3), 2 gives g0&g1&g2&g3.
- R4: Mode 3 is a latch set by g0|g1 and cleared by g2|g3. When both are active, set wins.
- R5: Mode 4 is a D flip-flop. Clock is g0, data is g1, reset is g2 (highest priority) and set is g3. The state changes only on a rising edge of g0, or through set or reset.
- R6: Mode 5 is a D flip-flop with data g1&g3, clocked by a g0 rising edge and reset by g2.
- R7: Mode 6 is a JK flip-flop with J=g1, K=g3 and reset g2, clocked by a g0 rising edge. J=K=1 toggles the state.
- R8: Mode 7 is a latch that follows g1 while g0 is high and holds while g0 is low. Reset g2 wins over set g3.
- R9: `cell_out` shows the function result one system clock after its inputs are applied. Register 0 bit 1 inverts it.
- R10: While register 0 bit 0 (enable) is clear, `cell_out` is 0 and the stored state is cleared.
- R11: A 0-to-1 step of `cell_out` sets `rise_flag` when register 0 bit 2 is set. A 1-to-0 step sets `fall_flag` when bit 3 is set. Both flags change in the same cycle as `cell_out`. `irq` is high while either flag is set.
- R12: A flag stays set until a write to register 10 with data bit 0 (rise) or bit 1 (fall) set. A new edge in that same cycle wins over the clear.
- R13: After reset every register is 0, and `cell_out`, both flags and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| src | input | NSRC | Candidate input sources |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 4 | Register address |
| wr_data | input | 8 | Register write data |
| cell_out | output | 1 | Registered cell output |
| rise_flag | output | 1 | Sticky rising-edge flag |
| fall_flag | output | 1 | Sticky falling-edge flag |
| irq | output | 1 | Interrupt request, high while a flag is set |

## Verification
The assertions assume that `src` and the write port change only between clock edges and are stable at each rising edge. They also assume that no write targets an address above 10. The bench changes inputs only on falling edges and writes only addresses 0 to 10. Flip-flop modes get clock edges only as single steps of one source bit, held for at least one cycle.

// File: rtl/cfg_logic_cell.sv
module cfg_logic_cell #(
  parameter int NSRC = 15,
  parameter int SELW = $clog2(NSRC + 1)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] src,
  input  logic            wr_en,
  input  logic [3:0]      wr_addr,
  input  logic [7:0]      wr_data,
  output logic            cell_out,
  output logic            rise_flag,
  output logic            fall_flag,
  output logic            irq
);
  localparam int NBANK = 1 << SELW;

  logic            en_q, inv_q, rie_q, fie_q;
  logic [2:0]      mode_q;
  logic [SELW-1:0] sel_q [4];
  logic [7:0]      gcfg_q [4];
  logic [3:0]      ginv_q;

  logic [NBANK-1:0] bank;
  logic [3:0]       d, g;
  logic             q, q_nxt, g0_d, clk_edge, comb_f, out_nxt;
  logic             clr_r, clr_f;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {en_q, inv_q, rie_q, fie_q} <= '0;
      mode_q <= '0;
      ginv_q <= '0;
      for (int k = 0; k < 4; k++) begin
        sel_q[k]  <= '0;
        gcfg_q[k] <= '0;
      end
    end else if (wr_en) begin
      if (wr_addr == 4'd0) begin
        {en_q, inv_q, rie_q, fie_q} <= {wr_data[0], wr_data[1], wr_data[2], wr_data[3]};
        mode_q <= wr_data[6:4];
      end
      if (wr_addr == 4'd9) ginv_q <= wr_data[3:0];
      for (int k = 0; k < 4; k++) begin
        if (wr_addr == 4'(1 + k)) sel_q[k]  <= wr_data[SELW-1:0];
        if (wr_addr == 4'(5 + k)) gcfg_q[k] <= wr_data;
      end
    end
  end

  always_comb begin
    bank = '0;
    bank[NSRC-1:0] = src;
    bank[NSRC] = cell_out;
  end

  always_comb
    for (int k = 0; k < 4; k++) begin
      d[k] = bank[sel_q[k]];
      g[k] = ((|(gcfg_q[k][3:0] & d)) | (|(gcfg_q[k][7:4] & ~d))) ^ ginv_q[k];
    end

  assign clk_edge = g[0] & ~g0_d;

  always_comb begin
    q_nxt = q;
    case (mode_q)
      3'd3: q_nxt = (g[0] | g[1]) ? 1'b1 : ((g[2] | g[3]) ? 1'b0 : q);
      3'd4: q_nxt = g[2] ? 1'b0 : g[3] ? 1'b1 : clk_edge ? g[1] : q;
      3'd5: q_nxt = g[2] ? 1'b0 : clk_edge ? (g[1] & g[3]) : q;
      3'd6: q_nxt = g[2] ? 1'b0 : clk_edge ? ((g[1] & ~q) | (~g[3] & q)) : q;
      3'd7: q_nxt = g[2] ? 1'b0 : g[3] ? 1'b1 : g[0] ? g[1] : q;
      default: q_nxt = q;
    endcase
  end

  always_comb
    case (mode_q)
      3'd0:    comb_f = (g[0] & g[1]) | (g[2] & g[3]);
      3'd1:    comb_f = (g[0] | g[1]) ^ (g[2] | g[3]);
      3'd2:    comb_f = &g;
      default: comb_f = q_nxt;
    endcase

  assign out_nxt = en_q & (comb_f ^ inv_q);
  assign clr_r   = wr_en && wr_addr == 4'd10 && wr_data[0];
  assign clr_f   = wr_en && wr_addr == 4'd10 && wr_data[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q         <= 1'b0;
      g0_d      <= 1'b0;
      cell_out  <= 1'b0;
      rise_flag <= 1'b0;
      fall_flag <= 1'b0;
    end else begin
      q         <= en_q & q_nxt;
      g0_d      <= g[0];
      cell_out  <= out_nxt;
      rise_flag <= (rie_q & out_nxt & ~cell_out) | (rise_flag & ~clr_r);
      fall_flag <= (fie_q & ~out_nxt & cell_out) | (fall_flag & ~clr_f);
    end
  end

  assign irq = rise_flag | fall_flag;

  a_r10_disabled_low: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> !cell_out);
  a_r11_rise_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (rie_q && !cell_out && out_nxt) |=> (rise_flag && irq));
  a_r11_no_rise_unarmed: assert property (@(posedge clk) disable iff (!rst_n)
    (!rie_q && !rise_flag) |=> !rise_flag);
  a_r12_rise_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (rise_flag && !clr_r) |=> rise_flag);
  a_r12_fall_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (fall_flag && !clr_f) |=> fall_flag);
endmodule

// File: tb/tb_cfg_logic_cell.sv
module tb_cfg_logic_cell;
  localparam int NS = 15;
  localparam time CLK_PERIOD = 10ns;

  logic          clk = 1'b0, rst_n = 1'b0;
  logic [NS-1:0] src = '0;
  logic          wr_en = 1'b0;
  logic [3:0]    wr_addr = '0;
  logic [7:0]    wr_data = '0;
  logic          cell_out, rise_flag, fall_flag, irq;
  int            n_chk = 0, n_bad = 0;

  cfg_logic_cell #(.NSRC(NS)) dut (
    .clk(clk), .rst_n(rst_n), .src(src), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cell_out(cell_out), .rise_flag(rise_flag),
    .fall_flag(fall_flag), .irq(irq)
  );

  always #(CLK_PERIOD / 2) clk = ~clk;

  // {mode[2:0], src[3:0], expected}, default gates g_k = d_k
  localparam logic [7:0] VEC [10] = '{
    {3'd0, 4'b0011, 1'b1}, {3'd0, 4'b1100, 1'b1}, {3'd0, 4'b0101, 1'b0},
    {3'd0, 4'b1010, 1'b0}, {3'd1, 4'b0001, 1'b1}, {3'd1, 4'b0101, 1'b0},
    {3'd1, 4'b0100, 1'b1}, {3'd1, 4'b0000, 1'b0}, {3'd2, 4'b1111, 1'b1},
    {3'd2, 4'b1110, 1'b0}
  };

  task automatic chk(input string req, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %b expected %b", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [7:0] v);
    wr_en = 1'b1; wr_addr = a; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic step(input logic [3:0] s);
    src = NS'(s);
    @(negedge clk);
  endtask

  task automatic defaults();
    for (int k = 0; k < 4; k++) begin
      wr(4'(1 + k), 8'(k));
      wr(4'(5 + k), 8'(1 << k));
    end
    wr(4'd9, 8'h00);
  endtask

  task automatic seq_mode(input logic [2:0] m);
    src = '0;
    wr(4'd0, 8'h00);
    wr(4'd0, {1'b0, m, 4'b0001});
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R13 out", cell_out, 1'b0);
    chk("R13 rise", rise_flag, 1'b0);
    chk("R13 irq", irq, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
    step(4'b1111);
    chk("R13 disabled after reset", cell_out, 1'b0);
    defaults();

    foreach (VEC[i]) begin
      wr(4'd0, {1'b0, VEC[i][7:5], 4'b0001});
      step(VEC[i][4:1]);
      chk("R3/R9 vector", cell_out, VEC[i][0]);
    end

    wr(4'd0, 8'h23); step(4'b1111); chk("R9 polarity", cell_out, 1'b0);
    wr(4'd0, 8'h20); step(4'b1111); chk("R10 disabled", cell_out, 1'b0);

    // R2 gate0 variants, gates 1..3 forced to 1
    wr(4'd6, 8'h00); wr(4'd7, 8'h00); wr(4'd8, 8'h00);
    wr(4'd9, 8'h0E); wr(4'd0, 8'h21);
    wr(4'd5, 8'h30);
    step(4'b0011); chk("R2 nand both high", cell_out, 1'b0);
    step(4'b0001); chk("R2 nand one low", cell_out, 1'b1);
    wr(4'd5, 8'h03); wr(4'd9, 8'h0F);
    step(4'b0000); chk("R2 nor zeros", cell_out, 1'b1);
    step(4'b0010); chk("R2 nor one high", cell_out, 1'b0);
    wr(4'd5, 8'h00);
    step(4'b1111); chk("R2 const 1", cell_out, 1'b1);
    wr(4'd9, 8'h0E);
    step(4'b1111); chk("R2 const 0", cell_out, 1'b0);

    // R1 source select
    wr(4'd5, 8'h01); wr(4'd1, 8'd9);
    src = NS'(1 << 9); @(negedge clk); chk("R1 pick src9 high", cell_out, 1'b1);
    src = NS'(1);      @(negedge clk); chk("R1 pick src9 low", cell_out, 1'b0);

    // R1 feedback toggle: g0 = ~own output
    wr(4'd0, 8'h20); wr(4'd1, 8'(NS)); wr(4'd5, 8'h10); wr(4'd0, 8'h21);
    @(negedge clk); chk("R1 feedback t1", cell_out, 1'b1);
    @(negedge clk); chk("R1 feedback t2", cell_out, 1'b0);
    @(negedge clk); chk("R1 feedback t3", cell_out, 1'b1);
    wr(4'd0, 8'h20);
    defaults();

    seq_mode(3'd4);
    step(4'b0010); chk("R5 no edge hold", cell_out, 1'b0);
    step(4'b0011); chk("R5 capture 1", cell_out, 1'b1);
    step(4'b0001); chk("R5 clock high hold", cell_out, 1'b1);
    step(4'b0000);
    step(4'b0001); chk("R5 capture 0", cell_out, 1'b0);
    step(4'b1000); chk("R5 set", cell_out, 1'b1);
    step(4'b0100); chk("R5 reset", cell_out, 1'b0);
    step(4'b1000); step(4'b1100); chk("R5 reset wins", cell_out, 1'b0);

    seq_mode(3'd3);
    step(4'b0100); chk("R4 clear", cell_out, 1'b0);
    step(4'b0010); chk("R4 set", cell_out, 1'b1);
    step(4'b0000); chk("R4 hold", cell_out, 1'b1);
    step(4'b1000); chk("R4 clear2", cell_out, 1'b0);
    step(4'b1001); chk("R4 set wins", cell_out, 1'b1);

    seq_mode(3'd5);
    step(4'b0010); step(4'b0011); chk("R6 data and low", cell_out, 1'b0);
    step(4'b1010); step(4'b1011); chk("R6 capture", cell_out, 1'b1);
    step(4'b1111); chk("R6 reset", cell_out, 1'b0);

    seq_mode(3'd6);
    step(4'b1010); chk("R7 idle", cell_out, 1'b0);
    step(4'b1011); chk("R7 toggle up", cell_out, 1'b1);
    step(4'b1010); chk("R7 no edge", cell_out, 1'b1);
    step(4'b1011); chk("R7 toggle down", cell_out, 1'b0);
    step(4'b0010); step(4'b0011); chk("R7 J set", cell_out, 1'b1);
    step(4'b0100); chk("R7 reset", cell_out, 1'b0);

    seq_mode(3'd7);
    step(4'b0010); chk("R8 closed", cell_out, 1'b0);
    step(4'b0011); chk("R8 open follow 1", cell_out, 1'b1);
    step(4'b0001); chk("R8 open follow 0", cell_out, 1'b0);
    step(4'b0000); step(4'b0010); chk("R8 closed hold", cell_out, 1'b0);
    step(4'b1000); chk("R8 set", cell_out, 1'b1);
    step(4'b1100); chk("R8 reset wins", cell_out, 1'b0);

    // R11/R12 flags, gates 1..3 forced 1, mode 2
    src = '0;
    wr(4'd6, 8'h00); wr(4'd7, 8'h00); wr(4'd8, 8'h00); wr(4'd9, 8'h0E);
    wr(4'd0, 8'h25);
    step(4'b0001);
    chk("R11 rise flag", rise_flag, 1'b1);
    chk("R11 irq", irq, 1'b1);
    step(4'b0000);
    chk("R11 fall unarmed", fall_flag, 1'b0);
    chk("R12 sticky", rise_flag, 1'b1);
    wr(4'd10, 8'h01);
    chk("R12 cleared", rise_flag, 1'b0);
    chk("R12 irq low", irq, 1'b0);
    wr(4'd0, 8'h2D);
    step(4'b0001); step(4'b0000);
    chk("R11 fall flag", fall_flag, 1'b1);
    wr(4'd10, 8'h02);
    chk("R12 fall cleared", fall_flag, 1'b0);
    chk("R12 rise kept", rise_flag, 1'b1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule